// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block models the write sequencer of an embedded flash. It takes decoded commands on a one-cycle request strobe and sequences word program and block erase operations. While it does so it keeps an 8-bit status byte that software polls. A behavioural array model drives the other side. Each time a program or erase pulse has been applied and verified, the model raises `vfy_valid` for one cycle. `vfy_pass` carries the verdict. The supply level on `vsup_ok` is looked at only in that cycle.

The sequencer has five states:
- `ST_IDLE`: ready.
- `ST_PROG`: busy programming.
- `ST_ERASE`: busy erasing.
- `ST_PSUSP`: program suspended, ready.
- `ST_ESUSP`: erase suspended, ready.

The transitions are:
- start-program: `ST_IDLE` to `ST_PROG`.
- start-erase: `ST_IDLE` to `ST_ERASE`.
- finish (verify pass, pulse limit reached, or supply low): `ST_PROG`/`ST_ERASE` back to `ST_IDLE`.
- suspend: `ST_PROG` to `ST_PSUSP`, and `ST_ERASE` to `ST_ESUSP`.
- resume: `ST_PSUSP` to `ST_PROG`, and `ST_ESUSP` to `ST_ERASE`. The pulse count is kept across the suspension.
- lock-abort: `ST_IDLE` to `ST_IDLE`, taken when a start targets a locked block.

The error bits are sticky. Only a clear command issued while the block is ready removes them.

Top module: `flash_wsm_status`

## Requirements
- R1: After reset the status byte reads 0x80. Its bit layout from bit 7 down is: ready, erase-suspended, erase-error, program-error, supply-error, program-suspended, lock-abort, and bit 0, which always reads 0. `ready` equals status bit 7.
- R2: Command codes on `cmd_code` are: 0 read status (no effect), 1 program, 2 erase, 3 program suspend, 4 program resume, 5 erase suspend, 6 erase resume, 7 clear status. An accepted program or erase makes bit 7 read 0 from the cycle after the command. A verify with `vfy_pass`=1 returns bit 7 to 1 with no error bit set.
- R3: An erase suspend during an erase sets bits 7 and 6 the cycle after. Bit 6 stays 1 until an erase resume, which makes the block busy again. Verify reports that arrive while the erase is suspended are ignored, and the failed-pulse count reached before the suspend is kept.
- R4: A program suspend during a program sets bits 7 and 2. Bit 2 stays 1 until a program resume, which makes the block busy again.
- R5: Bit 5 is set, and the erase ends, only on the ERASE_MAX-th failing erase verify (default 8). A passing verify before then ends the erase with no error.
- R6: Bit 4 is set, and the program ends, on the PROG_MAX-th failing program verify (default 4).
- R7: A program or erase command with `blk_locked`=1 does not make the block busy and sets bit 1.
- R8: `vsup_ok` is examined only when `vfy_valid`=1 during a program or erase. At other times a low level has no effect. A low level at verify sets bit 3 and ends the operation.
- R9: With parameter ZERO_VOLT_OK=1, bit 3 always reads 0 and a verify with the supply low is treated only by its pass/fail verdict.
- R10: Bits 5, 4, 3 and 1 hold until a clear command. A clear is accepted only while bit 7 is 1 and is ignored while busy.
- R11: A resume with nothing suspended is ignored. A program or erase command while busy or suspended is ignored. A suspend that does not match the running operation is ignored.
- R12: If a suspend command and a verify report arrive in the same cycle, the suspend wins and the verify report is discarded without being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code (see R2) |
| blk_locked | input | 1 | Lock state of the block targeted by the current command |
| vsup_ok | input | 1 | Program/erase supply within range |
| vfy_valid | input | 1 | Array model finished one pulse and its verify |
| vfy_pass | input | 1 | Verify verdict, valid with `vfy_valid` |
| status | output | 8 | Status byte |
| ready | output | 1 | Sequencer ready (status bit 7) |

## Verification
The bench goes after the count boundaries:
- An erase that fails exactly ERASE_MAX times must flag bit 5, while ERASE_MAX-1 failures must not. An off-by-one counter would set the error one pulse early or let the erase run on.
- A suspend that straddles failed pulses must keep its count. A design that clears or bumps the count would end the resumed erase at the wrong pulse.

It also checks that a suspend landing on the same cycle as a verify swallows that report. It drives a low supply outside the verify cycle to catch a design that watches the supply continuously. It sends a clear while busy to catch a design that lets sticky errors drop mid-operation. A second instance with the zero-volt option shows that bit 3 never rises and the low-supply verify does not end the operation.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_PROG  = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_PSUS  = 3'd3,
        CMD_PRES  = 3'd4,
        CMD_ESUS  = 3'd5,
        CMD_ERES  = 3'd6,
        CMD_CLR   = 3'd7
    } wsm_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_PSUSP = 3'd3,
        ST_ESUSP = 3'd4
    } wsm_state_e;

endpackage

// File: rtl/wsm_pulse_ctr.sv
module wsm_pulse_ctr #(
    parameter int PROG_MAX  = 4,
    parameter int ERASE_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic sel_erase,
    output logic last
);
    localparam int MAXP = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        lim  = sel_erase ? CW'(ERASE_MAX - 1) : CW'(PROG_MAX - 1);
        last = (cnt == lim);
    end

    // R5, R6: the failed-pulse count never passes the larger limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < MAXP);

endmodule

// File: rtl/wsm_err_flags.sv
module wsm_err_flags #(
    parameter bit ZERO_VOLT_OK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic ev_clear,
    input  logic ev_lock,
    input  logic ev_vlow,
    input  logic ev_perr,
    input  logic ev_eerr,
    output logic flag_lock,
    output logic flag_vlow,
    output logic flag_perr,
    output logic flag_eerr
);
    always_ff @(posedge clk) begin
        if (!rst_n || ev_clear) begin
            flag_lock <= 1'b0;
            flag_perr <= 1'b0;
            flag_eerr <= 1'b0;
        end else begin
            flag_lock <= flag_lock | ev_lock;
            flag_perr <= flag_perr | ev_perr;
            flag_eerr <= flag_eerr | ev_eerr;
        end
    end

    generate
        if (ZERO_VOLT_OK) begin : g_no_vsense
            assign flag_vlow = 1'b0;
        end else begin : g_vsense
            logic vlow_q;
            always_ff @(posedge clk) begin
                if (!rst_n || ev_clear) begin
                    vlow_q <= 1'b0;
                end else begin
                    vlow_q <= vlow_q | ev_vlow;
                end
            end
            assign flag_vlow = vlow_q;
        end
    endgenerate

    // R10: nothing sticky drops while the sequencer is busy
    a_r10_no_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> ({flag_lock, flag_vlow, flag_perr, flag_eerr}
                      & $past({flag_lock, flag_vlow, flag_perr, flag_eerr}))
                     == $past({flag_lock, flag_vlow, flag_perr, flag_eerr}));

endmodule

// File: rtl/wsm_seq_fsm.sv
module wsm_seq_fsm
    import flash_wsm_pkg::*;
#(
    parameter bit ZERO_VOLT_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  wsm_cmd_e   cmd,
    input  logic       blk_locked,
    input  logic       vsup_ok,
    input  logic       vfy_valid,
    input  logic       vfy_pass,
    input  logic       cnt_last,
    output wsm_state_e state,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       ev_lock,
    output logic       ev_vlow,
    output logic       ev_perr,
    output logic       ev_eerr,
    output logic       ev_clear
);
    wsm_state_e nxt;
    logic       vlow;

    assign vlow = !ZERO_VOLT_OK && !vsup_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt      = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        ev_lock  = 1'b0;
        ev_vlow  = 1'b0;
        ev_perr  = 1'b0;
        ev_eerr  = 1'b0;
        ev_clear = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && (cmd == CMD_PROG || cmd == CMD_ERASE)) begin
                    if (blk_locked) begin
                        ev_lock = 1'b1;
                    end else begin
                        cnt_clr = 1'b1;
                        nxt     = (cmd == CMD_PROG) ? ST_PROG : ST_ERASE;
                    end
                end else if (cmd_valid && cmd == CMD_CLR) begin
                    ev_clear = 1'b1;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (cmd_valid && state == ST_PROG && cmd == CMD_PSUS) begin
                    nxt = ST_PSUSP;
                end else if (cmd_valid && state == ST_ERASE && cmd == CMD_ESUS) begin
                    nxt = ST_ESUSP;
                end else if (vfy_valid) begin
                    if (vlow) begin
                        ev_vlow = 1'b1;
                        nxt     = ST_IDLE;
                    end else if (vfy_pass) begin
                        nxt = ST_IDLE;
                    end else if (cnt_last) begin
                        ev_perr = (state == ST_PROG);
                        ev_eerr = (state == ST_ERASE);
                        nxt     = ST_IDLE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_PSUSP: begin
                if (cmd_valid && cmd == CMD_PRES) begin
                    nxt = ST_PROG;
                end else if (cmd_valid && cmd == CMD_CLR) begin
                    ev_clear = 1'b1;
                end
            end
            ST_ESUSP: begin
                if (cmd_valid && cmd == CMD_ERES) begin
                    nxt = ST_ERASE;
                end else if (cmd_valid && cmd == CMD_CLR) begin
                    ev_clear = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R3: erase suspend lands in the erase-suspended state
    a_r3_esus_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && cmd_valid && cmd == CMD_ESUS) |=> state == ST_ESUSP);

    // R7: a locked target never makes the sequencer busy
    a_r7_lock_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && blk_locked
         && (cmd == CMD_PROG || cmd == CMD_ERASE)) |=> state == ST_IDLE);

    // R11: resume with nothing suspended is ignored
    a_r11_resume_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && (cmd == CMD_PRES || cmd == CMD_ERES))
        |=> state == ST_IDLE);

    // R12: suspend beats a same-cycle verify report
    a_r12_susp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && cmd_valid && cmd == CMD_PSUS && vfy_valid)
        |=> state == ST_PSUSP);

endmodule

// File: rtl/flash_wsm_status.sv
module flash_wsm_status
    import flash_wsm_pkg::*;
#(
    parameter int PROG_MAX     = 4,
    parameter int ERASE_MAX    = 8,
    parameter bit ZERO_VOLT_OK = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       blk_locked,
    input  logic       vsup_ok,
    input  logic       vfy_valid,
    input  logic       vfy_pass,
    output logic [7:0] status,
    output logic       ready
);
    wsm_state_e state;
    logic cnt_clr, cnt_inc, cnt_last;
    logic ev_lock, ev_vlow, ev_perr, ev_eerr, ev_clear;
    logic flag_lock, flag_vlow, flag_perr, flag_eerr;

    wsm_seq_fsm #(.ZERO_VOLT_OK(ZERO_VOLT_OK)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (wsm_cmd_e'(cmd_code)),
        .blk_locked (blk_locked),
        .vsup_ok    (vsup_ok),
        .vfy_valid  (vfy_valid),
        .vfy_pass   (vfy_pass),
        .cnt_last   (cnt_last),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .ev_lock    (ev_lock),
        .ev_vlow    (ev_vlow),
        .ev_perr    (ev_perr),
        .ev_eerr    (ev_eerr),
        .ev_clear   (ev_clear)
    );

    wsm_pulse_ctr #(.PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .sel_erase (state == ST_ERASE),
        .last      (cnt_last)
    );

    wsm_err_flags #(.ZERO_VOLT_OK(ZERO_VOLT_OK)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready),
        .ev_clear  (ev_clear),
        .ev_lock   (ev_lock),
        .ev_vlow   (ev_vlow),
        .ev_perr   (ev_perr),
        .ev_eerr   (ev_eerr),
        .flag_lock (flag_lock),
        .flag_vlow (flag_vlow),
        .flag_perr (flag_perr),
        .flag_eerr (flag_eerr)
    );

    always_comb begin
        ready  = (state == ST_IDLE) || (state == ST_PSUSP) || (state == ST_ESUSP);
        status = {ready, state == ST_ESUSP, flag_eerr, flag_perr,
                  flag_vlow, state == ST_PSUSP, flag_lock, 1'b0};
    end

    // R8: supply error rises only after a verify seen with the supply low
    a_r8_vlow_at_verify: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> $past(vfy_valid && !vsup_ok));

    // R4: program-suspended flag implies ready
    a_r4_psusp_ready: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> ready);

endmodule

// File: tb/sim_flash_wsm_status.sv
module sim_flash_wsm_status;

    localparam int PMAX = 4;
    localparam int EMAX = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       blk_locked = 1'b0;
    logic       vsup_ok = 1'b1;
    logic       vfy_valid = 1'b0;
    logic       vfy_pass = 1'b0;
    logic [7:0] status, status1;
    logic       ready, ready1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_wsm_status #(.PROG_MAX(PMAX), .ERASE_MAX(EMAX), .ZERO_VOLT_OK(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .blk_locked(blk_locked), .vsup_ok(vsup_ok), .vfy_valid(vfy_valid),
        .vfy_pass(vfy_pass), .status(status), .ready(ready));

    flash_wsm_status #(.PROG_MAX(PMAX), .ERASE_MAX(EMAX), .ZERO_VOLT_OK(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .blk_locked(blk_locked), .vsup_ok(vsup_ok), .vfy_valid(vfy_valid),
        .vfy_pass(vfy_pass), .status(status1), .ready(ready1));

    // behavioural reference: mode 0 idle, 1 prog, 2 erase, 3 prog held, 4 erase held
    int m_mode = 0;
    int m_fails = 0;
    bit m_lock = 0, m_vlow = 0, m_perr = 0, m_eerr = 0;

    function automatic logic [7:0] m_status();
        bit rdy;
        rdy = (m_mode == 0) || (m_mode >= 3);
        return {rdy, m_mode == 4, m_eerr, m_perr, m_vlow, m_mode == 3, m_lock, 1'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_fails = 0;
            m_lock = 0; m_vlow = 0; m_perr = 0; m_eerr = 0;
        end else if (m_mode == 0) begin
            if (cmd_valid && (cmd_code == 3'd1 || cmd_code == 3'd2)) begin
                if (blk_locked) m_lock = 1;
                else begin m_mode = cmd_code; m_fails = 0; end
            end else if (cmd_valid && cmd_code == 3'd7) begin
                m_lock = 0; m_vlow = 0; m_perr = 0; m_eerr = 0;
            end
        end else if (m_mode == 1 || m_mode == 2) begin
            if (cmd_valid && m_mode == 1 && cmd_code == 3'd3) m_mode = 3;
            else if (cmd_valid && m_mode == 2 && cmd_code == 3'd5) m_mode = 4;
            else if (vfy_valid) begin
                if (!vsup_ok) begin m_vlow = 1; m_mode = 0; end
                else if (vfy_pass) m_mode = 0;
                else begin
                    m_fails++;
                    if (m_mode == 1 && m_fails == PMAX) begin m_perr = 1; m_mode = 0; end
                    if (m_mode == 2 && m_fails == EMAX) begin m_eerr = 1; m_mode = 0; end
                end
            end
        end else begin
            if (cmd_valid && m_mode == 3 && cmd_code == 3'd4) m_mode = 1;
            else if (cmd_valid && m_mode == 4 && cmd_code == 3'd6) m_mode = 2;
            else if (cmd_valid && cmd_code == 3'd7) begin
                m_lock = 0; m_vlow = 0; m_perr = 0; m_eerr = 0;
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R1, R2) and the zero-volt copy (R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 per-cycle status", status, m_status());
            check("R1 per-cycle ready", {7'd0, ready}, {7'd0, status[7]});
            check("R9 per-cycle bit3", {7'd0, status1[3]}, 8'd0);
        end
    end

    task automatic cmd(input logic [2:0] c, input logic lk = 1'b0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; blk_locked = lk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd0; blk_locked = 1'b0;
    endtask

    task automatic vfy(input logic p, input logic v = 1'b1);
        @(negedge clk);
        vfy_valid = 1'b1; vfy_pass = p; vsup_ok = v;
        @(negedge clk);
        vfy_valid = 1'b0; vfy_pass = 1'b0; vsup_ok = 1'b1;
    endtask

    task automatic susp_vfy(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; vfy_valid = 1'b1; vfy_pass = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd0; vfy_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 8'h80);

        // program passing on second verify
        cmd(3'd1);
        check("R2 program busy", status, 8'h00);
        vfy(1'b0);
        vfy(1'b1);
        check("R2 program done", status, 8'h80);

        // program exhausting its pulses, with an ignored erase mid-way
        cmd(3'd1);
        cmd(3'd2);
        check("R11 erase while busy", status, 8'h00);
        for (int i = 0; i < PMAX - 1; i++) vfy(1'b0);
        check("R6 before limit", status, 8'h00);
        vfy(1'b0);
        check("R6 program error", status, 8'h90);
        cmd(3'd7);
        check("R10 clear", status, 8'h80);

        // erase exhausting its pulses
        cmd(3'd2);
        for (int i = 0; i < EMAX - 1; i++) vfy(1'b0);
        check("R5 one short of limit", status, 8'h00);
        vfy(1'b0);
        check("R5 erase error", status, 8'hA0);
        cmd(3'd7);

        // locked target, then clear while busy
        cmd(3'd1, 1'b1);
        check("R7 lock abort", status, 8'h82);
        cmd(3'd2);
        cmd(3'd7);
        check("R10 clear while busy ignored", status, 8'h02);
        vfy(1'b1);
        check("R10 flag kept", status, 8'h82);
        cmd(3'd7);
        check("R10 clear when ready", status, 8'h80);

        // supply low only between verifies, then at verify
        cmd(3'd1);
        @(negedge clk); vsup_ok = 1'b0;
        repeat (3) @(negedge clk);
        vsup_ok = 1'b1;
        check("R8 low supply outside verify", status, 8'h00);
        vfy(1'b0, 1'b0);
        check("R8 supply error", status, 8'h88);
        check("R9 zero-volt copy still busy", status1, 8'h00);
        vfy(1'b1);
        check("R9 zero-volt copy done", status1, 8'h80);
        cmd(3'd7);

        // erase suspend keeps the pulse count
        cmd(3'd2);
        for (int i = 0; i < 3; i++) vfy(1'b0);
        cmd(3'd5);
        check("R3 erase suspended", status, 8'hC0);
        vfy(1'b0);
        cmd(3'd4);
        check("R3 held through verify and wrong resume", status, 8'hC0);
        cmd(3'd6);
        check("R3 erase resumed", status, 8'h00);
        for (int i = 0; i < EMAX - 4; i++) vfy(1'b0);
        check("R3 count kept before last", status, 8'h00);
        vfy(1'b0);
        check("R3 error at combined limit", status, 8'hA0);
        cmd(3'd7);

        // program suspend
        cmd(3'd1);
        cmd(3'd3);
        check("R4 program suspended", status, 8'h84);
        cmd(3'd2);
        check("R11 erase while suspended", status, 8'h84);
        cmd(3'd4);
        check("R4 program resumed", status, 8'h00);
        vfy(1'b1);
        check("R4 program done", status, 8'h80);

        // resumes and suspends with nothing running
        cmd(3'd6);
        cmd(3'd4);
        cmd(3'd5);
        check("R11 stray resume/suspend", status, 8'h80);

        // suspend and verify in the same cycle
        cmd(3'd1);
        vfy(1'b0);
        vfy(1'b0);
        susp_vfy(3'd3);
        check("R12 suspend wins", status, 8'h84);
        cmd(3'd4);
        vfy(1'b0);
        check("R12 report not counted", status, 8'h00);
        vfy(1'b0);
        check("R12 error at true limit", status, 8'h90);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule